// File: doc/BRIEF.md
# Reloading Down-Counter With Toggle Output

This block is a down-counting timer with a reload latch. It advances once for each single-cycle count enable pulse that an upstream prescaler delivers. When the counter is at zero and another pulse arrives, the counter underflows. It then reloads from the latch and keeps counting, so the distance between underflows is the latch value plus one pulses. Each underflow sets a sticky interrupt request. The request stays set until an explicit clear input removes it.

A control write sets a two-bit operating mode, a halt bit and a polarity bit. In pulse mode the output pin inverts at every underflow. In every other mode the pin keeps its level. A value write always loads the latch. It loads the counter as well only while the timer is halted. A value write also forces the pin to the start level given by the polarity bit, whether or not the timer is counting. A change of the polarity bit inverts the pin.

Top module: `toggle_timer`

## Requirements
- R1: After reset the counter reads 0xFF, the latch holds 0xFF, the timer is halted, the mode is 00, the polarity is 0, the pin is high and the interrupt request is low.
- R2: While the halt bit is 1, count enable pulses leave the counter unchanged.
- R3: While the halt bit is 0, a count enable pulse with the counter above zero lowers it by one on the next edge.
- R4: A count enable pulse while running with the counter at zero reloads the counter from the latch and sets the interrupt request on the next edge.
- R5: The interrupt request stays set until irq_clr is asserted. If a clear and an underflow fall in the same cycle, the request stays set.
- R6: A value write always loads the latch. It also loads the counter only when the halt bit was 1 before that edge. Otherwise the counter keeps counting.
- R7: A value write sets the pin to the inverse of the polarity bit in effect after that edge. Polarity 0 gives high and polarity 1 gives low.
- R8: A control write that changes the polarity bit, with no value write in that cycle, inverts the pin.
- R9: In mode 01 (pulse mode), every underflow inverts the pin.
- R10: In modes 00, 10 and 11, an underflow leaves the pin unchanged.
- R11: With a latch value of N and a pulse on every cycle while running, underflows occur every N+1 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Single-cycle count pulse from the prescaler |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Operating mode; 01 is pulse mode, all other values are timer mode |
| ctl_halt | input | 1 | Halt bit; 1 stops counting |
| ctl_pol | input | 1 | Polarity bit; 0 starts the pin high, 1 starts it low |
| val_we | input | 1 | Value write strobe |
| val_data | input | W | Value written to the latch, and to the counter while halted |
| irq_clr | input | 1 | Clears the interrupt request |
| count_o | output | W | Current counter value |
| pin_o | output | 1 | Toggle output level |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
Every result is registered, so each stimulus shows up on count_o, pin_o and irq_o exactly one edge after it is applied, and never later. The bench drives inputs after a falling edge and advances its reference state for that same edge. It then samples the outputs one time unit after the next rising edge, so each comparison is made in the cycle where the change is due. Directed steps pin down the underflow cycle, the clear-versus-underflow collision, a value write while running and a polarity flip. A seeded random run then compares all three outputs after every edge.

// File: rtl/toggle_timer.sv
module toggle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         ctl_we,
  input  logic [1:0]   ctl_mode,
  input  logic         ctl_halt,
  input  logic         ctl_pol,
  input  logic         val_we,
  input  logic [W-1:0] val_data,
  input  logic         irq_clr,
  output logic [W-1:0] count_o,
  output logic         pin_o,
  output logic         irq_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [1:0]   MODE_PULSE = 2'b01;

  logic [W-1:0] cnt_q, latch_q;
  logic [1:0]   mode_q;
  logic         halt_q, pol_q, pin_q, irq_q;

  logic tick, uflow, pol_next, pol_flip, uf_flip;

  assign tick     = cnt_en & ~halt_q;
  assign uflow    = tick & (cnt_q == '0);
  assign pol_next = ctl_we ? ctl_pol : pol_q;
  assign pol_flip = ctl_we & (ctl_pol ^ pol_q);
  assign uf_flip  = uflow & (mode_q == MODE_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      halt_q <= 1'b1;
      pol_q  <= 1'b0;
    end else if (ctl_we) begin
      mode_q <= ctl_mode;
      halt_q <= ctl_halt;
      pol_q  <= ctl_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_q <= ALL_ONES;
    else if (val_we) latch_q <= val_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= ALL_ONES;
    else if (val_we && halt_q) cnt_q <= val_data;
    else if (uflow)            cnt_q <= latch_q;
    else if (tick)             cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (uflow)   irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b1;
    else if (val_we) pin_q <= ~pol_next;
    else             pin_q <= pin_q ^ pol_flip ^ uf_flip;
  end

  assign count_o = cnt_q;
  assign pin_o   = pin_q;
  assign irq_o   = irq_q;

  // R2
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !val_we) |=> $stable(count_o));

  // R3
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !halt_q && count_o != '0 && !val_we) |=> count_o == $past(count_o) - 1'b1);

  // R4
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !halt_q && count_o == '0) |=> (irq_o && count_o == $past(latch_q)));

  // R5
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr) |=> irq_o);

  // R6
  a_r6_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |=> latch_q == $past(val_data));

  // R7
  a_r7_start_level: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |=> pin_o == ~pol_q);

  // R8, R9
  a_r8_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_we && (ctl_we && ctl_pol != pol_q) != (cnt_en && !halt_q && count_o == '0 && mode_q == MODE_PULSE))
    |=> pin_o != $past(pin_o));

  // R10
  a_r10_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!val_we && !(ctl_we && ctl_pol != pol_q) && mode_q != MODE_PULSE) |=> $stable(pin_o));

endmodule

// File: tb/toggle_timer_tb.sv
module toggle_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cw = 1'b0, ch = 1'b0, cp = 1'b0, vw = 1'b0, cl = 1'b0;
  logic [1:0] cm = 2'b00;
  logic [7:0] vd = 8'h00;
  logic [7:0] count_o;
  logic pin_o, irq_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  logic [7:0] m_cnt, m_lat;
  logic [1:0] m_mode;
  logic m_halt, m_pol, m_pin, m_irq;

  always #4 clk = ~clk;

  toggle_timer #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(en), .ctl_we(cw), .ctl_mode(cm),
    .ctl_halt(ch), .ctl_pol(cp), .val_we(vw), .val_data(vd), .irq_clr(cl),
    .count_o(count_o), .pin_o(pin_o), .irq_o(irq_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_cnt = 8'hFF; m_lat = 8'hFF; m_mode = 2'b00;
    m_halt = 1'b1; m_pol = 1'b0; m_pin = 1'b1; m_irq = 1'b0;
  endtask

  task automatic model_step();
    logic tick, uf, pe;
    tick = en && !m_halt;
    uf   = tick && (m_cnt == 8'h00);
    pe   = cw ? cp : m_pol;
    if (vw) m_pin = ~pe;
    else    m_pin = m_pin ^ (cw && (cp != m_pol)) ^ (uf && m_mode == 2'b01);
    if (uf) m_irq = 1'b1; else if (cl) m_irq = 1'b0;
    if (vw && m_halt) m_cnt = vd;
    else if (uf)      m_cnt = m_lat;
    else if (tick)    m_cnt = m_cnt - 8'd1;
    if (vw) m_lat = vd;
    if (cw) begin m_mode = cm; m_halt = ch; m_pol = cp; end
  endtask

  task automatic drive(logic e, logic w, logic [1:0] m, logic h, logic p,
                       logic v, logic [7:0] d, logic c);
    en = e; cw = w; cm = m; ch = h; cp = p; vw = v; vd = d; cl = c;
    model_step();
    @(posedge clk); #1;
    chk("R3 count", count_o, m_cnt);
    chk("R5 irq", irq_o, m_irq);
    chk("R9 pin", pin_o, m_pin);
    @(negedge clk);
  endtask

  task automatic idle_tick(logic c);
    drive(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, c);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count_o, 8'hFF);
    chk("R1 irq", irq_o, 0);
    chk("R1 pin", pin_o, 1);

    drive(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R2 halted", count_o, 8'hFF);

    drive(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 8'd3, 1'b0);
    chk("R6 halted load", count_o, 3);
    chk("R7 pol0 high", pin_o, 1);

    drive(1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    idle_tick(1'b0); chk("R3 dec", count_o, 2);
    idle_tick(1'b0); idle_tick(1'b0);
    chk("R11 no irq before period", irq_o, 0);
    idle_tick(1'b0);
    chk("R11 irq after 4 pulses", irq_o, 1);
    chk("R4 reload", count_o, 3);
    chk("R9 pulse toggle", pin_o, 0);

    drive(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    chk("R5 clear", irq_o, 0);
    idle_tick(1'b0); idle_tick(1'b0); idle_tick(1'b0);
    idle_tick(1'b1);
    chk("R5 clear loses to underflow", irq_o, 1);
    chk("R9 toggle back", pin_o, 1);

    drive(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 8'd7, 1'b0);
    chk("R6 running no counter load", count_o, 2);

    drive(1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R8 pol flip", pin_o, 0);

    drive(1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    idle_tick(1'b0); idle_tick(1'b0); idle_tick(1'b0);
    chk("R10 timer mode hold", pin_o, 0);
    chk("R4 reload 7", count_o, 7);

    drive(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 8'd5, 1'b0);
    chk("R7 pol1 low", pin_o, 0);

    void'($urandom(32'h0BADF00D));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] rm;
      logic [7:0] rd;
      rm = 2'($urandom_range(0, 3));
      rd = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 6));
      drive(($urandom_range(0, 1) == 1),
            ($urandom_range(0, 19) == 0), rm,
            ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 1) == 1),
            ($urandom_range(0, 19) == 0), rd,
            ($urandom_range(0, 9) == 0));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule